// File: doc/BRIEF.md
# Audio Transmit Interrupt Status Unit

This unit turns the status flags of an audio transmit channel into interrupt status. The flags are half-empty, empty and busy, plus a pulse that marks an underrun event. It holds one sticky condition, the underrun. Software clears that condition by writing a one to a clear register. The other two status bits simply track their flags. A software-writable enable register masks the raw status, and the OR of the masked bits drives a single level-sensitive interrupt line.

Every output is registered. Raw status, masked status and the interrupt line therefore reflect the flags, the enables and the register writes seen at the previous rising clock edge. Raw status is re-evaluated in every cycle, so it is current after every register write and after every drain event. A wide read view presents the raw status in its low bits and zeros above.

Top module: `atx_irq_unit`

## Requirements
- R1: Raw status bit 0 (transmit request) equals the half-empty flag sampled at the previous clock edge.
- R2: Raw status bit 2 (transmit complete) is 1 only when, at the previous edge, the FIFO was empty and the transmitter was not busy.
- R3: Raw status bit 1 (underrun) becomes 1 one cycle after an underrun pulse. It then stays 1 while the other flags change, until it is cleared.
- R4: A write to address 1 (clear register) with data bit 0 set makes the underrun bit 0 one cycle later. A write there with data bit 0 clear leaves the underrun bit unchanged.
- R5: When an underrun pulse and a clearing write arrive in the same cycle, the underrun bit is 1 afterwards.
- R6: A write to address 0 loads the enable register from the low 3 data bits, one bit per raw status position. The enable read port returns that value one cycle later, and the higher data bits are dropped.
- R7: Masked status equals raw status AND enable. The interrupt line is 1 exactly when the masked status is non-zero, and it follows a flag or enable change with one cycle of latency.
- R8: The combined read view carries the raw status in bits 2:0 and zero in every higher bit, including bits 6:3.
- R9: While reset is active, the enable register, raw status, masked status, combined view and interrupt line are all 0.
- R10: Writes to addresses 2 and 3 change neither the enable register nor the underrun bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_empty | input | 1 | Transmit FIFO at or below half full |
| fifo_empty | input | 1 | Transmit FIFO holds no samples |
| tx_busy | input | 1 | Transmitter is still shifting data out |
| underrun_set | input | 1 | One-cycle pulse: FIFO drained to empty |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (2) | Register address: 0 enable, 1 clear |
| wr_data | input | DATA_W (32) | Register write data |
| enable_rd | output | 3 | Enable register contents |
| raw_status | output | 3 | Raw interrupt status {complete, underrun, request} |
| masked_status | output | 3 | Raw status AND enable |
| combined_rd | output | DATA_W (32) | Raw status zero-extended for a wide read |
| irq | output | 1 | Level interrupt line |

## Verification
The bench aims at four cases. The first is an underrun pulse and a clearing write in the same cycle: a design that gives the clear priority would lose an event. The second is a clear write with bit 0 low, which a design that decodes the whole register would wrongly treat as a clear. The third is the complete bit while the transmitter is busy, which a design that uses only the empty flag would raise too early. The fourth is enable writes with high data bits set and writes to unused addresses: a design that decodes too few address bits would corrupt the enable register or the underrun bit.

// File: rtl/atx_irq_pkg.sv
package atx_irq_pkg;
    localparam int RAW_W   = 3;
    localparam int REQ_BIT = 0;
    localparam int UND_BIT = 1;
    localparam int CMP_BIT = 2;

    typedef struct packed {
        logic [RAW_W-1:0] raw;
        logic [RAW_W-1:0] en;
        logic             und;
        logic             irq;
    } irq_state_t;
endpackage

// File: rtl/atx_irq_raw_eval.sv
module atx_irq_raw_eval
    import atx_irq_pkg::*;
(
    input  logic             half_empty,
    input  logic             fifo_empty,
    input  logic             tx_busy,
    input  logic             und_flag,
    output logic [RAW_W-1:0] raw
);
    always_comb begin
        raw          = '0;
        raw[REQ_BIT] = half_empty;
        raw[UND_BIT] = und_flag;
        raw[CMP_BIT] = fifo_empty & ~tx_busy;
    end
endmodule

// File: rtl/atx_irq_sticky.sv
module atx_irq_sticky (
    input  logic cur,
    input  logic set_evt,
    input  logic clr_evt,
    output logic nxt
);
    // a new event outranks a simultaneous clear so it is never lost
    always_comb begin
        nxt = set_evt | (cur & ~clr_evt);
    end
endmodule

// File: rtl/atx_irq_mask_gate.sv
module atx_irq_mask_gate
    import atx_irq_pkg::*;
(
    input  logic [RAW_W-1:0] raw,
    input  logic [RAW_W-1:0] en,
    output logic [RAW_W-1:0] masked,
    output logic             any
);
    for (genvar i = 0; i < RAW_W; i++) begin : g_bit
        assign masked[i] = raw[i] & en[i];
    end
    assign any = |masked;
endmodule

// File: rtl/atx_irq_unit.sv
module atx_irq_unit
    import atx_irq_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 2,
    parameter int EN_ADDR  = 0,
    parameter int CLR_ADDR = 1,
    parameter int CLR_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_empty,
    input  logic              fifo_empty,
    input  logic              tx_busy,
    input  logic              underrun_set,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [RAW_W-1:0]  enable_rd,
    output logic [RAW_W-1:0]  raw_status,
    output logic [RAW_W-1:0]  masked_status,
    output logic [DATA_W-1:0] combined_rd,
    output logic              irq
);
    localparam int PAD_W = DATA_W - RAW_W;

    irq_state_t st_d, st_q;

    logic             en_wr, clr_wr;
    logic             und_d;
    logic [RAW_W-1:0] raw_d;
    logic [RAW_W-1:0] masked_d;
    logic             any_d;
    logic             any_q;

    assign en_wr  = wr_en && (wr_addr == ADDR_W'(EN_ADDR));
    assign clr_wr = wr_en && (wr_addr == ADDR_W'(CLR_ADDR)) && wr_data[CLR_BIT];

    atx_irq_sticky u_und (
        .cur     (st_q.und),
        .set_evt (underrun_set),
        .clr_evt (clr_wr),
        .nxt     (und_d)
    );

    atx_irq_raw_eval u_raw (
        .half_empty (half_empty),
        .fifo_empty (fifo_empty),
        .tx_busy    (tx_busy),
        .und_flag   (und_d),
        .raw        (raw_d)
    );

    always_comb begin
        st_d     = st_q;
        st_d.und = und_d;
        st_d.raw = raw_d;
        if (en_wr) begin
            st_d.en = wr_data[RAW_W-1:0];
        end
        st_d.irq = any_d;
    end

    atx_irq_mask_gate u_gate_d (
        .raw    (raw_d),
        .en     (st_d.en),
        .masked (masked_d),
        .any    (any_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    atx_irq_mask_gate u_gate_q (
        .raw    (st_q.raw),
        .en     (st_q.en),
        .masked (masked_status),
        .any    (any_q)
    );

    assign enable_rd   = st_q.en;
    assign raw_status  = st_q.raw;
    assign combined_rd = {{PAD_W{1'b0}}, st_q.raw};
    assign irq         = st_q.irq;
endmodule

// File: rtl/atx_irq_unit_chk.sv
module atx_irq_unit_chk
    import atx_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              half_empty,
    input logic              fifo_empty,
    input logic              tx_busy,
    input logic              underrun_set,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [RAW_W-1:0]  enable_rd,
    input logic [RAW_W-1:0]  raw_status,
    input logic [RAW_W-1:0]  masked_status,
    input logic [DATA_W-1:0] combined_rd,
    input logic              irq
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1
    req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> raw_status[REQ_BIT] == $past(half_empty));

    // R2
    cmp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> raw_status[CMP_BIT] == $past(fifo_empty && !tx_busy));

    // R5
    und_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_set |=> raw_status[UND_BIT]);

    // R4
    und_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && wr_data[0] && !underrun_set)
        |=> !raw_status[UND_BIT]);

    // R7
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(raw_status & enable_rd));

    // R8
    view_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        combined_rd[DATA_W-1:RAW_W] == '0);
endmodule

bind atx_irq_unit atx_irq_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/atx_irq_unit_test.sv
module atx_irq_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          half_empty = 0, fifo_empty = 0, tx_busy = 0, underrun_set = 0;
    logic          wr_en = 0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [2:0]    enable_rd, raw_status, masked_status;
    logic [DW-1:0] combined_rd;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [2:0] m_en  = '0;
    logic       m_und = 1'b0;
    logic [2:0] m_raw = '0;
    logic       m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    atx_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .half_empty(half_empty), .fifo_empty(fifo_empty),
        .tx_busy(tx_busy), .underrun_set(underrun_set), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .enable_rd(enable_rd),
        .raw_status(raw_status), .masked_status(masked_status),
        .combined_rd(combined_rd), .irq(irq)
    );

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic model_und(logic cur, logic s, logic we, logic [1:0] a,
                                       logic [DW-1:0] d);
        return s | (cur & ~(we && a == 2'd1 && d[0]));
    endfunction

    task automatic check_all();
        check("R1 request bit", DW'(raw_status[0]), DW'(m_raw[0]));
        check("R3 underrun bit", DW'(raw_status[1]), DW'(m_raw[1]));
        check("R2 complete bit", DW'(raw_status[2]), DW'(m_raw[2]));
        check("R6 enable readback", DW'(enable_rd), DW'(m_en));
        check("R7 masked status", DW'(masked_status), DW'(m_raw & m_en));
        check("R7 irq line", DW'(irq), DW'(m_irq));
        check("R8 combined view", combined_rd, DW'(m_raw));
    endtask

    // check the current outputs, then apply new inputs and advance the model
    task automatic step(logic h, logic e, logic b, logic s, logic we,
                        logic [1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        check_all();
        half_empty = h; fifo_empty = e; tx_busy = b; underrun_set = s;
        wr_en = we; wr_addr = a; wr_data = d;
        m_und = model_und(m_und, s, we, a, d);
        if (we && a == 2'd0) m_en = d[2:0];
        m_raw = {e & ~b, m_und, h};
        m_irq = |(m_raw & m_en);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        half_empty = 1; fifo_empty = 1; underrun_set = 1;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 enable in reset", DW'(enable_rd), 0);
        check("R9 raw in reset", DW'(raw_status), 0);
        check("R9 masked in reset", DW'(masked_status), 0);
        check("R9 combined in reset", combined_rd, 0);
        check("R9 irq in reset", DW'(irq), 0);
        half_empty = 0; fifo_empty = 0; underrun_set = 0;
        @(negedge clk);
        rst_n = 1'b1;

        // R6 enable load drops high bits
        step(0, 0, 0, 0, 1, 2'd0, 32'hFFFF_FFF8 | 32'h7);
        step(1, 1, 1, 0, 0, 2'd0, 0);
        // R2 empty but busy: complete stays low
        step(0, 1, 0, 0, 0, 2'd0, 0);
        step(0, 0, 0, 1, 0, 2'd0, 0);
        // R3 underrun holds while flags move
        step(1, 0, 1, 0, 0, 2'd0, 0);
        step(0, 1, 1, 0, 0, 2'd0, 0);
        // R4 clear write with bit 0 low keeps underrun
        step(0, 0, 0, 0, 1, 2'd1, 32'hFFFF_FFFE);
        @(negedge clk);
        check("R4 clear without bit0 keeps underrun", DW'(raw_status[1]), 1);
        // R10 writes to unused addresses ignored
        step(0, 0, 0, 0, 1, 2'd2, 32'hFFFF_FFFF);
        step(0, 0, 0, 0, 1, 2'd3, 32'h0000_0000);
        @(negedge clk);
        check("R10 enable untouched", DW'(enable_rd), 7);
        check("R10 underrun untouched", DW'(raw_status[1]), 1);
        // R4 proper clear
        step(0, 0, 0, 0, 1, 2'd1, 32'h1);
        @(negedge clk);
        check("R4 underrun cleared", DW'(raw_status[1]), 0);
        // R5 set and clear together: set wins
        step(0, 0, 0, 1, 1, 2'd1, 32'h1);
        @(negedge clk);
        check("R5 set beats clear", DW'(raw_status[1]), 1);
        // R7 mask only complete bit
        step(1, 0, 0, 0, 1, 2'd0, 32'h4);
        step(1, 0, 0, 0, 1, 2'd1, 32'h1);
        step(1, 1, 0, 0, 0, 2'd0, 0);
        @(negedge clk);
        check("R7 irq from complete only", DW'(irq), 1);

        for (int i = 0; i < 3000; i++) begin
            logic we;
            we = ($urandom % 4) == 0;
            step($urandom % 2, $urandom % 2, $urandom % 2, ($urandom % 8) == 0,
                 we, 2'($urandom % 4), $urandom);
        end
        step(0, 0, 0, 0, 0, 2'd0, 0);
        @(negedge clk);
        check_all();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule